// File: doc/BRIEF.md
# Clock divider bank with glitch-free output gating

This block is the digital back end of a zero-delay clock driver. It is clocked by a fast core clock `clk_i`. Each rising edge of the divider source is given to it as a one-cycle strobe. There are two such strobes: one from the oscillator and one from the reference. The `pll_en_i` input picks which of the two advances the dividers, so bypass mode still passes the clock through the dividers.

One shared divide-by-4 stage drives six gated clock outputs. A separate feedback divider drives the feedback output. Its ratio comes from a mode bit and a 2-bit select code. The odd ratio 5 gives a high time of 2 source periods and a low time of 3.

Each group of clock outputs has an active-low stop input, and a common stop acts on all clock outputs. Stops take hold and release only while the divided clock is low, so no pulse is ever shortened. A drive-enable input turns the output-enable vector off, which models a tri-state of every output.

Top module: `clkdiv_bank`

## Requirements
- R1: While reset is asserted, and after its release until the first source strobe, every output is low. The first selected strobe after reset makes all enabled Q outputs and the feedback output rise together.
- R2: Each Q output divides the selected source by 4. It is high for the 1st and 2nd strobes of each 4-strobe period, counting from reset, and low for the 3rd and 4th.
- R3: With `mode_i`=0, feedback select codes 2'b00, 2'b01 and 2'b10 divide by 8, 10 and 12. For a ratio N, `qfb_o` is high after strobes k with k mod N in 1..N/2 and low otherwise.
- R4: With `mode_i`=1, codes 2'b00, 2'b01 and 2'b10 divide by 4, 5 and 6, using the same high window. Divide-by-5 is high for 2 strobes and low for 3.
- R5: Feedback select code 2'b11 is illegal in both modes, and it holds `qfb_o` low.
- R6: When `pll_en_i`=1 only `vco_tick_i` advances the dividers. When it is 0 only `ref_tick_i` does. The other strobe has no effect.
- R7: Stop input `sd_ni[0]` low holds both Q0 and Q1 low. Bits `sd_ni[1]` to `sd_ni[4]` hold Q2 to Q5 low.
- R8: A stop or release only takes effect while the divided clock is low and not rising in that cycle. A Q output therefore rises only when the divided clock rises and falls only when it falls.
- R9: `com_sd_ni` low holds all Q outputs low and never affects `qfb_o`.
- R10: `oe_o` is all ones when `drive_en_i`=1 and all zeros when it is 0. Bits 5:0 belong to Q5..Q0 and bit 6 to the feedback output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| vco_tick_i | input | 1 | Oscillator edge strobe |
| ref_tick_i | input | 1 | Reference edge strobe (bypass) |
| pll_en_i | input | 1 | 1 selects oscillator strobe, 0 selects reference |
| mode_i | input | 1 | Feedback ratio range select |
| fbsel_i | input | 2 | Feedback ratio code |
| sd_ni | input | 5 | Active-low stops: bit0 Q0/Q1, bits1-4 Q2..Q5 |
| com_sd_ni | input | 1 | Active-low common stop for all Q outputs |
| drive_en_i | input | 1 | Output drive enable |
| q_o | output | 6 | Gated divided clocks Q5..Q0 |
| qfb_o | output | 1 | Feedback clock |
| oe_o | output | 7 | Output enables, bit 6 for feedback |

## Verification
The assertions take for granted that `mode_i` and `fbsel_i` change only while reset is held. Under that assumption the divider counters stay in range and the illegal-code check never sees a stale high level. The bench writes a new configuration only inside a reset phase, including the illegal code. It then randomises strobes, source selection, stops and drive enable freely.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int CNT_W = 4;

  // feedback ratio per mode/code; 0 marks an illegal setting
  function automatic logic [CNT_W-1:0] fb_ratio(input logic mode, input logic [1:0] sel);
    logic [CNT_W-1:0] base;
    case (sel)
      2'b00:   base = CNT_W'(4);
      2'b01:   base = CNT_W'(5);
      2'b10:   base = CNT_W'(6);
      default: base = '0;
    endcase
    return mode ? base : (base << 1);
  endfunction

  // stop-input index serving a given Q output
  function automatic int stop_index(input int q);
    return (q < 2) ? 0 : q - 1;
  endfunction
endpackage

// File: rtl/clkdiv_rst_sync.sv
module clkdiv_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/clkdiv_div.sv
module clkdiv_div #(
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic [CW-1:0] ratio_i,
  output logic          level_o,
  output logic          level_nxt_o
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          lvl_q, lvl_d;

  always_comb begin
    cnt_d = cnt_q;
    lvl_d = lvl_q;
    if (ratio_i == '0) begin
      cnt_d = '0;
      lvl_d = 1'b0;
    end else if (tick_i) begin
      cnt_d = (cnt_q >= ratio_i - ONE) ? '0 : cnt_q + ONE;
      lvl_d = (cnt_d != '0) && (cnt_d <= (ratio_i >> 1));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      lvl_q <= lvl_d;
    end
  end

  assign level_o     = lvl_q;
  assign level_nxt_o = lvl_d;

  // R2
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ratio_i == '0) || (cnt_q < ratio_i));
  // R6
  no_tick_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && ratio_i != '0) |=> $stable(lvl_q));
endmodule

// File: rtl/clkdiv_gate.sv
module clkdiv_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic level_i,
  input  logic level_nxt_i,
  output logic q_o
);
  logic gate_q, gate_d;
  logic open_win;

  // enable may change only in the low phase, never in a rising cycle
  assign open_win = !level_i && !level_nxt_i;

  always_comb begin
    gate_d = gate_q;
    if (open_win) gate_d = en_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= 1'b0;
    else         gate_q <= gate_d;
  end

  assign q_o = level_i & gate_q;

  // R8
  rise_with_clk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(q_o) |-> $rose(level_i));
  // R8
  fall_with_clk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(q_o) |-> $fell(level_i));
endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank #(
  parameter int NQ   = 6,
  parameter int NSD  = 5,
  parameter int CW   = clkdiv_pkg::CNT_W,
  parameter int QDIV = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           vco_tick_i,
  input  logic           ref_tick_i,
  input  logic           pll_en_i,
  input  logic           mode_i,
  input  logic [1:0]     fbsel_i,
  input  logic [NSD-1:0] sd_ni,
  input  logic           com_sd_ni,
  input  logic           drive_en_i,
  output logic [NQ-1:0]  q_o,
  output logic           qfb_o,
  output logic [NQ:0]    oe_o
);
  localparam logic [CW-1:0] Q_RATIO = CW'(QDIV);

  logic          rst_n;
  logic          src_tick;
  logic [CW-1:0] fb_ratio;
  logic          q_lvl, q_lvl_nxt;
  logic          fb_lvl, fb_lvl_nxt;

  clkdiv_rst_sync #(.STAGES(2)) u_rst (
    .clk_i (clk_i), .rst_ni(rst_ni), .rst_no(rst_n)
  );

  assign src_tick = pll_en_i ? vco_tick_i : ref_tick_i;
  assign fb_ratio = clkdiv_pkg::fb_ratio(mode_i, fbsel_i);

  clkdiv_div #(.CW(CW)) u_qdiv (
    .clk_i(clk_i), .rst_ni(rst_n), .tick_i(src_tick), .ratio_i(Q_RATIO),
    .level_o(q_lvl), .level_nxt_o(q_lvl_nxt)
  );

  clkdiv_div #(.CW(CW)) u_fbdiv (
    .clk_i(clk_i), .rst_ni(rst_n), .tick_i(src_tick), .ratio_i(fb_ratio),
    .level_o(fb_lvl), .level_nxt_o(fb_lvl_nxt)
  );

  for (genvar i = 0; i < NQ; i++) begin : g_out
    logic en;
    assign en = sd_ni[clkdiv_pkg::stop_index(i)] & com_sd_ni;
    clkdiv_gate u_gate (
      .clk_i(clk_i), .rst_ni(rst_n), .en_i(en),
      .level_i(q_lvl), .level_nxt_i(q_lvl_nxt), .q_o(q_o[i])
    );
  end

  assign qfb_o = fb_lvl;
  assign oe_o  = {(NQ+1){drive_en_i}};

  // R5
  illegal_fb_low_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (fbsel_i == 2'b11 && $past(fbsel_i) == 2'b11) |-> !qfb_o);
  // R9
  fb_free_of_stops_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!src_tick && fb_ratio != '0) |=> $stable(qfb_o));
  // R1
  fb_next_unused_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (fb_lvl_nxt && !fb_lvl) |=> $rose(qfb_o));
endmodule

// File: tb/sim_clkdiv_bank.sv
module sim_clkdiv_bank;
  logic clk = 1'b0;
  logic rst_n, vt, rt, pll, mode, com, drv;
  logic [1:0] sel;
  logic [4:0] sd;
  logic [5:0] q;
  logic qfb;
  logic [6:0] oe;
  int errors = 0, checks = 0;
  logic cmp_on = 1'b0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  clkdiv_bank u0 (
    .clk_i(clk), .rst_ni(rst_n), .vco_tick_i(vt), .ref_tick_i(rt),
    .pll_en_i(pll), .mode_i(mode), .fbsel_i(sel), .sd_ni(sd),
    .com_sd_ni(com), .drive_en_i(drv), .q_o(q), .qfb_o(qfb), .oe_o(oe)
  );

  function automatic int ratio_of(input logic m, input logic [1:0] s);
    int b;
    b = (s == 2'b00) ? 4 : (s == 2'b01) ? 5 : (s == 2'b10) ? 6 : 0;
    return m ? b : 2 * b;
  endfunction

  function automatic logic hi_at(input int k, input int n);
    if (n == 0) return 1'b0;
    return ((k % n) != 0) && ((k % n) <= n / 2);
  endfunction

  task automatic chk(input string tag, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural expectation built from the requirements
  int mk = 0, mcf = 0;
  logic [5:0] mgate;
  logic mq, mfb;
  always @(posedge clk) begin
    if (!rst_n) begin
      mk = 0; mcf = 0; mgate = '0; mq = 1'b0; mfb = 1'b0;
    end else begin
      logic tk, nq;
      int n;
      tk = pll ? vt : rt;
      n = ratio_of(mode, sel);
      nq = tk ? hi_at(mk + 1, 4) : mq;
      for (int i = 0; i < 6; i++)
        if (!mq && !nq) mgate[i] = sd[(i < 2) ? 0 : i - 1] & com;
      if (tk) begin
        mk = (mk + 1) % 4;
        mcf = (n == 0) ? 0 : (mcf + 1) % n;
      end
      mq = nq;
      mfb = hi_at(mcf, n);
    end
  end

  always @(negedge clk) if (cmp_on) begin
    chk("R2/R7/R8/R9 q", {1'b0, q}, {1'b0, {6{mq}} & mgate});
    chk(mode ? "R4/R9 qfb" : "R3/R9 qfb", {6'b0, qfb}, {6'b0, mfb});
    if (sel == 2'b11) chk("R5 qfb", {6'b0, qfb}, 7'b0);
    chk("R10 oe", oe, {7{drv}});
  end

  task automatic step(); @(posedge clk); #1; endtask

  task automatic do_reset(input logic m, input logic [1:0] s);
    rst_n = 1'b0; vt = 0; rt = 0; mode = m; sel = s;
    repeat (3) step();
    @(negedge clk);
    chk("R1 reset", {qfb, q}, 7'b0);
    rst_n = 1'b1;
    repeat (4) step();
    @(negedge clk);
    chk("R1 idle", {qfb, q}, 7'b0);
    step();
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 0; vt = 0; rt = 0; pll = 1; mode = 1; sel = 2'b01;
    sd = '1; com = 1; drv = 1;
    // directed: in-phase start, /4 and /5 pattern
    do_reset(1'b1, 2'b01);
    for (int k = 1; k <= 10; k++) begin
      vt = 1; step(); vt = 0;
      @(negedge clk);
      if (k == 1) chk("R1 in-phase", {qfb, q}, 7'h7f);
      chk("R2 q div4", {1'b0, q}, {1'b0, {6{hi_at(k, 4)}}});
      chk("R4 qfb div5", {6'b0, qfb}, {6'b0, hi_at(k, 5)});
      step();
    end
    // R6: unselected strobe ignored
    begin
      logic [6:0] snap;
      @(negedge clk); snap = {qfb, q};
      for (int k = 0; k < 8; k++) begin
        rt = 1; step(); rt = 0;
        @(negedge clk); chk("R6 ref ignored", {qfb, q}, snap);
      end
    end
    // R10 directed
    drv = 0; step(); @(negedge clk); chk("R10 oe off", oe, 7'h00);
    drv = 1; step(); @(negedge clk); chk("R10 oe on", oe, 7'h7f);
    // constrained random phases
    for (int ph = 0; ph < 8; ph++) begin
      logic m;
      logic [1:0] s;
      m = ph[0];
      s = (ph < 6) ? 2'(ph >> 1) : 2'($urandom_range(0, 3));
      if (ph == 7) s = 2'b11;
      step();
      do_reset(m, s);
      cmp_on = 1'b1;
      for (int c = 0; c < 1500; c++) begin
        vt = ($urandom_range(0, 1) == 1);
        rt = ($urandom_range(0, 2) == 0);
        if ($urandom_range(0, 49) == 0) pll = ~pll;
        if ($urandom_range(0, 29) == 0) sd[$urandom_range(0, 4)] ^= 1'b1;
        if ($urandom_range(0, 59) == 0) com = ~com;
        if ($urandom_range(0, 39) == 0) drv = ~drv;
        step();
      end
      @(negedge clk);
      cmp_on = 1'b0;
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule